// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block sets the instruction timing of a small microcontroller core whose program memory holds 16-bit words. It divides the oscillator clock into instruction cycles of four clocks each and drives one strobe per phase. In every instruction cycle it presents a program address, takes the word returned for that address at the end of the fourth phase, and moves it into the instruction register for the next cycle. The word that was latched in the previous cycle is executed at the same time.

Each latched word is tagged as a single-word instruction, the lead half of a double-word instruction, or a trailing word. The execute stage reports a taken conditional test (skip) or a program-counter write (jump with a target address). The sequencer then discards the prefetched word and runs a flush cycle in which the instruction register holds a no-operation word and the execute-valid flag is low. A trailing word executes as a no-operation: either it is the second half of a double-word instruction, or it is reached alone after a skip. The execute-valid flag is also low while it executes.

Top module: `quad_phase_seq`

## Requirements
- R1: While reset is applied and after its release, phase strobe 0 is the only strobe high (phase_o = 4'b0001), pc_o is 0, ir_o is 16'h0000, ir_kind_o is 2'b00 and ex_valid_o is low. The first instruction cycle after release is a flush cycle.
- R2: Exactly one phase strobe is high in every clock. The strobes step 0,1,2,3 and then wrap to 0, and each stays high for one clock.
- R3: pc_o, ir_o, ir_kind_o and ex_valid_o change only on the clock edge that ends phase 3. Inputs that toggle during phases 0 to 2 have no effect on them.
- R4: Without an accepted redirect, pc_o advances by one modulo 2^PC_W at the end of each cycle. The word present on fetch_word_i at that edge becomes ir_o for the next cycle.
- R5: A latched word is classed as follows. It is lead (ir_kind_o = 2'b01, ex_valid_o high) when bits [15:12] = 4'b1100 or bits [15:10] = 6'b111011. It is trailing (2'b10) when bits [15:12] = 4'b1111. Any other word is single (2'b00, ex_valid_o high).
- R6: The word latched right after a valid lead cycle is tagged trailing (2'b10) with ex_valid_o low, whatever its bits are.
- R7: A trailing-pattern word reached on its own is tagged 2'b10 with ex_valid_o low, so it executes as a no-operation.
- R8: A skip accepted at the end of a cycle makes the next cycle a flush: ir_o = 16'h0000, ir_kind_o = 2'b00, ex_valid_o low, and pc_o keeps advancing by one. The discarded word is therefore never executed.
- R9: A jump accepted at the end of a cycle loads pc_o with ex_target_i on that edge and makes the next cycle a flush. The word at the target is executed in the cycle after the flush.
- R10: When jump and skip are both asserted in an accepted cycle, the jump takes effect.
- R11: Redirect requests are accepted only in a valid single-word cycle or in the trailing cycle of a double-word pair. In flush cycles, lone trailing cycles and lead cycles they are ignored, and pc_o advances by one.
- R12: A jump asserted in the trailing cycle of a double-word pair gives the sequence lead cycle, trailing cycle, flush cycle, and then execution at the target: three instruction cycles in all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_word_i | input | WORD_W | Program word read at address pc_o |
| ex_skip_i | input | 1 | Execute stage: conditional test true, discard prefetched word |
| ex_jump_i | input | 1 | Execute stage: program counter write requested |
| ex_target_i | input | PC_W | New program counter value for a jump |
| phase_o | output | N_PHASE | One-hot phase strobes |
| pc_o | output | PC_W | Program counter, address being fetched |
| ir_o | output | WORD_W | Instruction register, word executing this cycle |
| ir_kind_o | output | 2 | Word class: 00 single, 01 lead, 10 trailing |
| ex_valid_o | output | 1 | High when the current cycle executes a real instruction |

## Verification
A corrupted phase counter appears on the strobes within one clock, and it shifts the pc_o and ir_o update edge away from the end of phase 3. A stuck pairing flag or a wrong acceptance decision appears one instruction cycle later. It shows as pc_o failing to take the target, as a redirect honoured in a cycle where it should be ignored, or as ex_valid_o high on a flushed or trailing word. A misclassified word appears in ir_kind_o and ex_valid_o in the same cycle the word is latched. Every instruction cycle compares all four cycle outputs against an independent model.

// File: rtl/qps_pkg.sv
package qps_pkg;

  typedef enum logic [1:0] {
    WK_SINGLE = 2'b00,
    WK_LEAD   = 2'b01,
    WK_TAIL   = 2'b10
  } word_kind_e;

  localparam int OPC_HI_W = 8;

  // lead half of a two-word instruction, judged on the top byte
  function automatic logic is_lead(input logic [OPC_HI_W-1:0] hi);
    return (hi[7:4] == 4'b1100) || (hi[7:2] == 6'b111011);
  endfunction

  // trailing word pattern: top nibble all ones
  function automatic logic is_tail(input logic [OPC_HI_W-1:0] hi);
    return hi[7:4] == 4'b1111;
  endfunction

endpackage

// File: rtl/qps_rst_sync.sv
module qps_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/qps_phase_gen.sv
module qps_phase_gen #(
  parameter int N_PHASE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [N_PHASE-1:0] phase_o,
  output logic               last_o
);

  localparam int CW = (N_PHASE > 1) ? $clog2(N_PHASE) : 1;
  localparam logic [CW-1:0] LAST = CW'(N_PHASE - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (cnt_q == LAST) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < N_PHASE; i++) begin : g_strobe
    assign phase_o[i] = (cnt_q == CW'(i));
  end

  assign last_o = (cnt_q == LAST);

endmodule

// File: rtl/qps_pc_unit.sv
module qps_pc_unit #(
  parameter int PC_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_en,
  input  logic            load_en,
  input  logic [PC_W-1:0] load_val,
  output logic [PC_W-1:0] pc_o
);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;

  always_comb begin
    if (load_en) begin
      pc_d = load_val;
    end else begin
      pc_d = pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (step_en) begin
      pc_q <= pc_d;
    end
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/qps_word_ctrl.sv
module qps_word_ctrl
  import qps_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [WORD_W-1:0] fetch_word,
  input  logic              ex_skip,
  input  logic              ex_jump,
  output logic [WORD_W-1:0] ir_o,
  output word_kind_e        kind_o,
  output logic              valid_o,
  output logic              paired_o,
  output logic              jump_take_o
);

  localparam logic [WORD_W-1:0] NOP_WORD = '0;

  logic [WORD_W-1:0]   ir_q, ir_d;
  word_kind_e          kind_q, kind_d;
  logic                valid_q, valid_d;
  logic                paired_q, paired_d;
  logic                accept;
  logic                skip_take;
  logic [OPC_HI_W-1:0] hi;

  assign hi = fetch_word[WORD_W-1 -: OPC_HI_W];

  always_comb begin
    accept      = valid_q ? (kind_q != WK_LEAD) : paired_q;
    jump_take_o = accept && ex_jump;
    skip_take   = accept && ex_skip && !ex_jump;

    ir_d     = fetch_word;
    kind_d   = WK_SINGLE;
    valid_d  = 1'b1;
    paired_d = 1'b0;

    if (jump_take_o || skip_take) begin
      ir_d    = NOP_WORD;
      valid_d = 1'b0;
    end else if (valid_q && (kind_q == WK_LEAD)) begin
      kind_d   = WK_TAIL;
      valid_d  = 1'b0;
      paired_d = 1'b1;
    end else if (is_tail(hi)) begin
      kind_d  = WK_TAIL;
      valid_d = 1'b0;
    end else if (is_lead(hi)) begin
      kind_d = WK_LEAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q     <= NOP_WORD;
      kind_q   <= WK_SINGLE;
      valid_q  <= 1'b0;
      paired_q <= 1'b0;
    end else if (tick) begin
      ir_q     <= ir_d;
      kind_q   <= kind_d;
      valid_q  <= valid_d;
      paired_q <= paired_d;
    end
  end

  assign ir_o     = ir_q;
  assign kind_o   = kind_q;
  assign valid_o  = valid_q;
  assign paired_o = paired_q;

endmodule

// File: rtl/quad_phase_seq.sv
module quad_phase_seq
  import qps_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int PC_W    = 12,
  parameter int N_PHASE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WORD_W-1:0]  fetch_word_i,
  input  logic               ex_skip_i,
  input  logic               ex_jump_i,
  input  logic [PC_W-1:0]    ex_target_i,
  output logic [N_PHASE-1:0] phase_o,
  output logic [PC_W-1:0]    pc_o,
  output logic [WORD_W-1:0]  ir_o,
  output logic [1:0]         ir_kind_o,
  output logic               ex_valid_o
);

  logic       rst_sync_n;
  logic       tick;
  logic       jump_take;
  logic       paired;
  word_kind_e kind;

  qps_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  qps_phase_gen #(.N_PHASE(N_PHASE)) u_phase (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .phase_o (phase_o),
    .last_o  (tick)
  );

  qps_word_ctrl #(.WORD_W(WORD_W)) u_word (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .tick        (tick),
    .fetch_word  (fetch_word_i),
    .ex_skip     (ex_skip_i),
    .ex_jump     (ex_jump_i),
    .ir_o        (ir_o),
    .kind_o      (kind),
    .valid_o     (ex_valid_o),
    .paired_o    (paired),
    .jump_take_o (jump_take)
  );

  qps_pc_unit #(.PC_W(PC_W)) u_pc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .step_en  (tick),
    .load_en  (jump_take),
    .load_val (ex_target_i),
    .pc_o     (pc_o)
  );

  assign ir_kind_o = kind;

endmodule

// File: rtl/quad_phase_seq_chk.sv
module quad_phase_seq_chk #(
  parameter int WORD_W  = 16,
  parameter int PC_W    = 12,
  parameter int N_PHASE = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_PHASE-1:0] phase,
  input logic [PC_W-1:0]    pc,
  input logic [WORD_W-1:0]  ir,
  input logic [1:0]         kind,
  input logic               valid,
  input logic               paired,
  input logic               skip,
  input logic               jump,
  input logic [PC_W-1:0]    target
);

  logic last;
  logic acc;

  assign last = phase[N_PHASE-1];
  assign acc  = valid ? (kind != 2'b01) : paired;

  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase) == 1);

  a_r2_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    phase[0] |=> phase[1]);

  a_r3_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(pc) && $stable(ir) && $stable(valid));

  a_r4_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !(acc && jump)) |=> pc == PC_W'($past(pc) + 1'b1));

  a_r6_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (last && valid && kind == 2'b01) |=> (kind == 2'b10 && !valid));

  a_r7_tail_nop: assert property (@(posedge clk) disable iff (!rst_n)
    kind == 2'b10 |-> !valid);

  a_r8_skip_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (last && acc && skip && !jump) |=> (!valid && ir == '0));

  a_r9_jump_load: assert property (@(posedge clk) disable iff (!rst_n)
    (last && acc && jump) |=> (pc == $past(target) && !valid));

  a_r11_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !acc) |=> pc == PC_W'($past(pc) + 1'b1));

endmodule

bind quad_phase_seq quad_phase_seq_chk #(
  .WORD_W (WORD_W),
  .PC_W   (PC_W),
  .N_PHASE(N_PHASE)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .phase  (phase_o),
  .pc     (pc_o),
  .ir     (ir_o),
  .kind   (ir_kind_o),
  .valid  (ex_valid_o),
  .paired (paired),
  .skip   (ex_skip_i),
  .jump   (ex_jump_i),
  .target (ex_target_i)
);

// File: tb/quad_phase_seq_tb.sv
module quad_phase_seq_tb;

  localparam int WORD_W  = 16;
  localparam int PC_W    = 12;
  localparam int N_PHASE = 4;
  localparam int N_CYC   = 2000;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [WORD_W-1:0]  fetch_word;
  logic               ex_skip;
  logic               ex_jump;
  logic [PC_W-1:0]    ex_target;
  logic [N_PHASE-1:0] phase_o;
  logic [PC_W-1:0]    pc_o;
  logic [WORD_W-1:0]  ir_o;
  logic [1:0]         ir_kind_o;
  logic               ex_valid_o;

  logic [15:0] mem [256];

  always #4 clk = ~clk;

  assign fetch_word = mem[pc_o[7:0]];

  quad_phase_seq #(.WORD_W(WORD_W), .PC_W(PC_W), .N_PHASE(N_PHASE)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_word_i (fetch_word),
    .ex_skip_i    (ex_skip),
    .ex_jump_i    (ex_jump),
    .ex_target_i  (ex_target),
    .phase_o      (phase_o),
    .pc_o         (pc_o),
    .ir_o         (ir_o),
    .ir_kind_o    (ir_kind_o),
    .ex_valid_o   (ex_valid_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [PC_W-1:0] m_pc, m_xaddr;
  logic [15:0]     m_ir;
  logic [1:0]      m_kind;
  logic            m_valid, m_paired;
  string           tag, ktag;

  task automatic chk(input string t, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
    end
  endtask

  function automatic logic lead_w(input logic [15:0] w);
    return (w[15:12] == 4'b1100) || (w[15:10] == 6'b111011);
  endfunction

  task automatic model_step(input logic sk, input logic jp, input logic [PC_W-1:0] tg);
    logic [15:0] w;
    logic acc;
    w   = mem[m_pc[7:0]];
    acc = m_valid ? (m_kind != 2'b01) : m_paired;
    if (acc && jp)                tag = m_paired ? "R12" : (sk ? "R10" : "R9");
    else if (acc && sk)           tag = "R8";
    else if (!acc && (sk || jp))  tag = "R11";
    else if (m_valid && m_kind == 2'b01) tag = "R6";
    else if (w[15:12] == 4'hF)    tag = "R7";
    else                          tag = "R4";
    ktag    = (tag == "R4") ? "R5" : tag;
    m_xaddr = m_pc;
    if (acc && (sk || jp)) begin
      m_ir = 16'h0000; m_kind = 2'b00; m_valid = 1'b0; m_paired = 1'b0;
    end else if (m_valid && m_kind == 2'b01) begin
      m_ir = w; m_kind = 2'b10; m_valid = 1'b0; m_paired = 1'b1;
    end else if (w[15:12] == 4'hF) begin
      m_ir = w; m_kind = 2'b10; m_valid = 1'b0; m_paired = 1'b0;
    end else begin
      m_ir = w; m_kind = lead_w(w) ? 2'b01 : 2'b00; m_valid = 1'b1; m_paired = 1'b0;
    end
    m_pc = (acc && jp) ? tg : m_pc + 1'b1;
  endtask

  task automatic check_hold(input logic [3:0] ph);
    chk("R2", "phase", 32'(phase_o), 32'(ph));
    chk("R3", "pc hold", 32'(pc_o), 32'(m_pc));
    chk("R3", "ir hold", 32'(ir_o), 32'(m_ir));
    chk("R3", "valid hold", 32'(ex_valid_o), 32'(m_valid));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int guard;
    logic sk, jp;
    logic [PC_W-1:0] tg;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
    mem[8'h00] = 16'h1111;
    mem[8'h01] = 16'h2222;
    mem[8'h02] = 16'hC0AA;
    mem[8'h03] = 16'hF0BB;
    mem[8'h04] = 16'hEC10;
    mem[8'h05] = 16'hF010;
    mem[8'h30] = 16'h1234;
    mem[8'h38] = 16'h4321;
    mem[8'hFF] = 16'h5555;

    rst_n = 1'b0; ex_skip = 1'b0; ex_jump = 1'b0; ex_target = '0;
    repeat (5) @(negedge clk);
    chk("R1", "reset phase", 32'(phase_o), 32'h1);
    chk("R1", "reset pc", 32'(pc_o), 32'h0);
    chk("R1", "reset ir", 32'(ir_o), 32'h0);
    chk("R1", "reset kind", 32'(ir_kind_o), 32'h0);
    chk("R1", "reset valid", 32'(ex_valid_o), 32'h0);
    rst_n = 1'b1;
    guard = 0;
    while (phase_o !== 4'b1000 && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    chk("R1", "first cycle pc", 32'(pc_o), 32'h0);
    chk("R1", "first cycle flush", 32'(ex_valid_o), 32'h0);

    m_pc = '0; m_ir = '0; m_kind = 2'b00; m_valid = 1'b0; m_paired = 1'b0; m_xaddr = '0;

    for (int c = 0; c < N_CYC; c++) begin
      sk = 1'b0; jp = 1'b0; tg = '0;
      if (c < 14) begin
        case (m_xaddr)
          12'h001: sk = 1'b1;
          12'h003: begin jp = 1'b1; tg = 12'h080; end
          12'h004: sk = 1'b1;
          12'h005: begin jp = 1'b1; tg = 12'h030; end
          12'h030: begin jp = 1'b1; sk = 1'b1; tg = 12'h038; end
          12'h038: begin jp = 1'b1; tg = 12'hFFF; end
          default: ;
        endcase
      end else begin
        int r;
        r  = int'($urandom % 16);
        jp = (r < 2) || (r == 4);
        sk = (r == 2) || (r == 3) || (r == 4);
        tg = PC_W'($urandom);
      end
      ex_skip = sk; ex_jump = jp; ex_target = tg;
      model_step(sk, jp, tg);

      @(negedge clk);
      chk("R2", "phase", 32'(phase_o), 32'h1);
      chk(tag, "pc", 32'(pc_o), 32'(m_pc));
      chk(tag, "ir", 32'(ir_o), 32'(m_ir));
      chk(ktag, "kind", 32'(ir_kind_o), 32'(m_kind));
      chk(tag, "valid", 32'(ex_valid_o), 32'(m_valid));

      @(negedge clk);
      check_hold(4'b0010);
      ex_skip = 1'($urandom); ex_jump = 1'($urandom); ex_target = PC_W'($urandom);
      @(negedge clk);
      check_hold(4'b0100);
      @(negedge clk);
      check_hold(4'b1000);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule